// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps the refresh cadence of an SDRAM device and performs each refresh without breaking into a data burst. Once the initialization logic reports that the device is ready, an interval counter runs freely and marks a refresh as owed every `REF_INTERVAL` clock cycles. The default of 1500 cycles gives about 15 µs at 100 MHz. That figure comes from a 64 ms retention time spread over 4096 rows. The owed refresh is shown to the access sequencer as a request. The scheduler waits for the sequencer's grant, which the sequencer gives only when it is idle or has finished its current burst.

Once granted, the scheduler owns the command pins. It closes all open rows with an all-bank PRECHARGE. It waits the row-precharge time, issues exactly one AUTO REFRESH, and waits the refresh-cycle time. Then it hands the bus back with a one-cycle completion pulse. The sequence needs no bank address and no mode-register load. In every cycle where it issues no command, the scheduler drives NOP.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The interval counter stays stopped until `init_done_i` has been seen high at a clock edge; after that it runs regardless of later values of `init_done_i`. The first request appears exactly `REF_INTERVAL` cycles after the edge that sampled `init_done_i` high.
- R2: Successive rising edges of `ref_req_o` are exactly `REF_INTERVAL` cycles apart. This holds however long the sequencer delays its grant, because the counter restarts when the request is raised.
- R3: `ref_req_o` stays high until a grant is accepted. The bus is taken only in the cycle after one where both `ref_req_o` and `ref_gnt_i` were high.
- R4: The first owned cycle carries PRECHARGE with `addr_o[AP_BIT]` (bit 10 by default) high and `ba_o` zero. Command encoding on {cs_n, ras_n, cas_n, we_n}: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001.
- R5: Exactly one AUTO REFRESH is issued per sequence. It comes exactly `T_RP` cycles after the PRECHARGE.
- R6: `bus_own_o` stays high from the PRECHARGE cycle up to `T_RC` cycles after the AUTO REFRESH. `ref_done_o` then pulses high for one cycle, exactly `T_RC` cycles after the AUTO REFRESH, with `bus_own_o` low.
- R7: NOP is driven on every cycle other than the two command cycles, including all cycles in which the bus is not owned and the period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Device initialization finished |
| ref_gnt_i | input | 1 | Sequencer idle or at a burst boundary; bus may be taken |
| ref_req_o | output | 1 | Refresh owed |
| bus_own_o | output | 1 | Scheduler drives the command pins |
| ref_done_o | output | 1 | One-cycle pulse: refresh finished, bus released |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins; bit AP_BIT selects all banks |
| ba_o | output | BA_W | Bank address, always zero |

## Verification
The hardest case to reach is drift-free spacing while refresh is deferred. The interval must be measured from one request to the next, not from the end of one refresh to the next. To test this, the stimulus holds the grant low for several cycles after the first request, as a long burst would. It then releases the grant and checks that the second request still rises exactly one interval after the first. A further case pulses `init_done_i` for a single cycle and drops it again, which checks that counter enabling is sticky.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_ARF = 4'b0001
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_TRP, S_ARF, S_TRC, S_DONE
  } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic start_i,
  output logic en_o,
  output logic pend_o
);
  localparam int unsigned CW = $clog2(INTERVAL);

  logic          en_q, pend_q, tick;
  logic [CW-1:0] cnt_q;

  assign tick = en_q && (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      en_q <= en_q | init_done_i;
      if (tick)       cnt_q <= '0;   // restart on raise, not on completion
      else if (en_q)  cnt_q <= cnt_q + 1'b1;
      if (tick)         pend_q <= 1'b1;
      else if (start_i) pend_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  a_r1_quiet_before_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pend_q);
  a_r3_hold_until_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start_i) |=> pend_q);
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import sdram_ref_pkg::*;
#(
  parameter int unsigned T_RP = 3,
  parameter int unsigned T_RC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic gnt_i,
  output logic start_o,
  output logic own_o,
  output logic done_o,
  output cmd_e cmd_o
);
  localparam int unsigned TMAX = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int unsigned WW   = $clog2(TMAX);
  localparam int unsigned GW   = $clog2(T_RP + T_RC + 2) + 1;

  ref_state_e    st_q, st_d;
  logic [WW-1:0] wcnt_q;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (pend_i && gnt_i) begin st_d = S_PRE; start_o = 1'b1; end
      S_PRE:  st_d = S_TRP;
      S_TRP:  if (wcnt_q == WW'(T_RP - 2)) st_d = S_ARF;
      S_ARF:  st_d = S_TRC;
      S_TRC:  if (wcnt_q == WW'(T_RC - 2)) st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= (st_d != st_q) ? '0 : wcnt_q + 1'b1;
    end
  end

  assign own_o  = (st_q == S_PRE) || (st_q == S_TRP) || (st_q == S_ARF) || (st_q == S_TRC);
  assign done_o = (st_q == S_DONE);
  assign cmd_o  = (st_q == S_PRE) ? CMD_PRE : (st_q == S_ARF) ? CMD_ARF : CMD_NOP;

  // checker counters: gaps measured independently of the wait counter
  logic [GW-1:0] since_pre_q, since_arf_q;
  logic [1:0]    arf_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre_q <= '0;
      since_arf_q <= '0;
      arf_n_q     <= '0;
    end else begin
      if (cmd_o == CMD_PRE)   since_pre_q <= GW'(1);
      else if (~&since_pre_q) since_pre_q <= since_pre_q + 1'b1;
      if (cmd_o == CMD_ARF)   since_arf_q <= GW'(1);
      else if (~&since_arf_q) since_arf_q <= since_arf_q + 1'b1;
      if (cmd_o == CMD_PRE)      arf_n_q <= '0;
      else if (cmd_o == CMD_ARF) arf_n_q <= arf_n_q + 1'b1;
    end
  end

  a_r5_trp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ARF) |-> (since_pre_q == GW'(T_RP)));
  a_r5_single_arf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (arf_n_q == 2'd1));
  a_r6_trc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (since_arf_q == GW'(T_RC)));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int unsigned REF_INTERVAL = 1500,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RC         = 7,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2,
  parameter int unsigned AP_BIT       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              ref_gnt_i,
  output logic              ref_req_o,
  output logic              bus_own_o,
  output logic              ref_done_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  logic en, pend, start;
  cmd_e cmd;

  ref_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_i),
    .start_i     (start),
    .en_o        (en),
    .pend_o      (pend)
  );

  ref_seq_fsm #(.T_RP(T_RP), .T_RC(T_RC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .gnt_i   (ref_gnt_i),
    .start_o (start),
    .own_o   (bus_own_o),
    .done_o  (ref_done_o),
    .cmd_o   (cmd)
  );

  assign ref_req_o = pend;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

  always_comb begin
    addr_o = '0;
    addr_o[AP_BIT] = (cmd == CMD_PRE);  // all-bank precharge
  end
  assign ba_o = '0;

  a_r3_take_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_own_o) |-> ($past(ref_gnt_i) && $past(ref_req_o)));
  a_r7_nop_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_own_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);
  a_r1_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> en);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 40;
  localparam int TRP        = 3;
  localparam int TRC        = 7;

  logic clk = 1'b0, rst_n = 1'b0, init_done = 1'b0, gnt = 1'b0;
  logic req, own, done, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  ba;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_sched #(.REF_INTERVAL(INTERVAL), .T_RP(TRP), .T_RC(TRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .ref_gnt_i(gnt),
    .ref_req_o(req), .bus_own_o(own), .ref_done_o(done),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba));

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // negedge monitor
  logic prev_req = 1'b0;
  int   rise_n = 0, rise_cyc[4];
  int   pre_cyc = -1, arf_cyc = -1, done_cyc = -1, arf_cnt = 0, own_cnt = 0, bad_cmd = 0;
  logic pre_a10 = 1'b0;
  logic [1:0] pre_ba = 2'b11;
  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (req && !prev_req && rise_n < 4) begin rise_cyc[rise_n] = cyc; rise_n++; end
    prev_req = req;
    if (own) own_cnt++;
    if (c == 4'b0010) begin pre_cyc = cyc; pre_a10 = addr[10]; pre_ba = ba; end
    else if (c == 4'b0001) begin arf_cyc = cyc; arf_cnt++; end
    else if (c != 4'b0111) bad_cmd++;
    if (!own && c != 4'b0111) bad_cmd++;
    if (done) done_cyc = cyc;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_req_rise(input int n);
    for (int i = 0; i < 4*INTERVAL && rise_n < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req == 0,  "R7 reset req", req, 0);
    chk(own == 0,  "R7 reset own", own, 0);
    chk(done == 0, "R7 reset done", done, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R7 reset NOP", {cs_n, ras_n, cas_n, we_n}, 7);
  endtask

  task automatic t_no_init;
    repeat (3*INTERVAL) @(negedge clk);
    chk(rise_n == 0, "R1 no request before init", rise_n, 0);
  endtask

  task automatic t_first_req(output int en_cyc);
    @(negedge clk);
    init_done = 1'b1;
    en_cyc = cyc + 1;       // edge that samples it
    @(negedge clk);
    init_done = 1'b0;       // sticky enable
    wait_req_rise(1);
    chk(rise_n == 1 && rise_cyc[0] == en_cyc + INTERVAL, "R1 first request timing",
        rise_cyc[0], en_cyc + INTERVAL);
    repeat (8) @(negedge clk);   // sequencer busy in burst
    chk(req == 1, "R3 request held", req, 1);
    chk(own_cnt == 0, "R3 no bus without grant", own_cnt, 0);
  endtask

  task automatic t_sequence(input string tag);
    int g;
    own_cnt = 0; arf_cnt = 0; pre_cyc = -1; arf_cyc = -1; done_cyc = -1;
    gnt = 1'b1; g = cyc;
    @(negedge clk);
    gnt = 1'b0;
    for (int i = 0; i < 40 && done_cyc < 0; i++) @(negedge clk);
    chk(pre_cyc == g + 1, {tag, " R3 take bus after grant"}, pre_cyc, g + 1);
    chk(pre_a10 == 1'b1 && pre_ba == 2'b00, {tag, " R4 all-bank precharge"}, {pre_a10, pre_ba}, 4);
    chk(arf_cyc - pre_cyc == TRP, {tag, " R5 tRP gap"}, arf_cyc - pre_cyc, TRP);
    chk(arf_cnt == 1, {tag, " R5 one refresh"}, arf_cnt, 1);
    chk(done_cyc - arf_cyc == TRC, {tag, " R6 done timing"}, done_cyc - arf_cyc, TRC);
    chk(own_cnt == TRP + TRC, {tag, " R6 ownership span"}, own_cnt, TRP + TRC);
    @(negedge clk);
    chk(done == 0 && req == 0, {tag, " R6 single done pulse"}, {done, req}, 0);
    chk(bad_cmd == 0, {tag, " R7 NOP elsewhere"}, bad_cmd, 0);
  endtask

  task automatic t_spacing(input int n);
    wait_req_rise(n);
    chk(rise_n >= n && rise_cyc[n-1] - rise_cyc[n-2] == INTERVAL, "R2 request spacing",
        rise_cyc[n-1] - rise_cyc[n-2], INTERVAL);
  endtask

  bit finished = 0;
  initial begin
    int en_cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_init();
    t_first_req(en_cyc);
    t_sequence("seq1");
    t_spacing(2);
    repeat (2) @(negedge clk);
    t_sequence("seq2");
    t_spacing(3);
    t_sequence("seq3");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule